// File: doc/BRIEF.md
# Energy Buffer Probe Sequencer

This block decides whether a checkpoint is needed. It measures the voltage of the energy storage element with an external ADC, and it powers that ADC only while a measurement runs. A probe request starts a fixed sequence of phases:

1. Power the ADC on for a programmed number of cycles.
2. Wait through ADC startup and conversion.
3. Move the conversion result into a sample register for a programmed transfer interval.
4. Switch the ADC off in one cycle.
5. Compare the sample with a programmed threshold in two cycles: a subtract, then a branch.

The branch cycle pulses `done`, together with either a checkpoint request or a plain return.

The ADC is outside the block. It appears only as a power-enable output, a data-valid input and a data bus. The phase lengths and the threshold are captured when a probe is accepted. A cycle counter records how long the latest probe took, so that software or a power model can account for the cost of each probe.

Top module: `energy_probe_seq`

## Requirements
- R1: A synchronous reset, applied at any time including in the middle of a probe, leaves `adc_pwr_en`, `busy`, `done`, `ckpt_req` and `ret` low and `probe_cycles` at zero in the following cycle.
- R2: `probe_req` sampled high while `busy` is low starts a probe. `busy` is high from the next cycle through the `done` cycle, and low in the cycle after it.
- R3: `adc_pwr_en` is high in exactly the cycles of the power-on, wait and transfer phases: one contiguous run that starts the cycle after acceptance. It is never high while `busy` is low or while `done` is high.
- R4: The power-on phase lasts Lon cycles and the transfer phase lasts Lx cycles. The wait phase ends in its first cycle that is at least its Lw-th cycle and in which `adc_valid` is high. The wait therefore lasts Lw cycles, or longer while `adc_valid` stays low.
- R5: The sample register takes `adc_data` in the final cycle of the wait phase. Later changes of `adc_data` have no effect on the decision.
- R6: Power-off takes one cycle, the subtract takes one cycle, and the branch takes one cycle. `done` pulses in the branch cycle, three cycles after the last powered cycle. In that cycle `ckpt_req` is high when the sample is strictly below the threshold (unsigned), and `ret` is high otherwise, including when the two are equal.
- R7: `probe_req` while `busy` is high, including in the `done` cycle, is ignored. The running probe keeps its timing, and no new probe follows unless a request is sampled while idle.
- R8: `probe_cycles` is cleared when a probe is accepted and increments in every busy cycle. After the probe it holds Lon + Lwait + Lx + 3 until the next accepted probe.
- R9: `on_cycles`, `wait_cycles`, `xfer_cycles` and `threshold` are captured at acceptance. Changing them during a probe does not alter it.
- R10: A programmed length of zero for any of the three timed phases is treated as one cycle (Lon = max(on_cycles,1), and likewise for Lw and Lx).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| probe_req | input | 1 | Request a probe |
| on_cycles | input | CNT_W | Power-on phase length |
| wait_cycles | input | CNT_W | Minimum startup-and-conversion wait |
| xfer_cycles | input | CNT_W | Transfer phase length |
| threshold | input | DATA_W | Checkpoint threshold |
| adc_valid | input | 1 | ADC result ready |
| adc_data | input | DATA_W | ADC result |
| adc_pwr_en | output | 1 | ADC power enable |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle end-of-probe pulse |
| ckpt_req | output | 1 | Checkpoint needed (with done) |
| ret | output | 1 | No checkpoint needed (with done) |
| probe_cycles | output | CYC_W | Cycle count of the current or latest probe |

## Verification
The bench sweeps every combination of small phase lengths, including zeros, against sample and threshold pairs at both unsigned extremes and at equality. A design that used a less-or-equal compare would raise a checkpoint on equality, and one that did not clamp zero lengths would end a phase early or hang. The bench delays `adc_valid` past the programmed wait, and it corrupts `adc_data` right after the capture cycle. This exposes a wait that ignores readiness and a sample latched at the wrong moment. It also scrambles the configuration during each probe, and it raises requests mid-probe and in the `done` cycle. A design that reads live settings, or restarts on a request in the `done` cycle, would shift `done` or leave `busy` high. A reset in the middle of a probe catches power left enabled.

// File: rtl/probe_seq_pkg.sv
package probe_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PWR_ON,
    PH_WAIT,
    PH_XFER,
    PH_PWR_OFF,
    PH_SUB,
    PH_BRANCH
  } phase_e;

endpackage

// File: rtl/probe_phase_ctrl.sv
module probe_phase_ctrl
  import probe_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             probe_req,
  input  logic [CNT_W-1:0] on_cycles,
  input  logic [CNT_W-1:0] wait_cycles,
  input  logic [CNT_W-1:0] xfer_cycles,
  input  logic             adc_valid,
  output logic             accept,
  output logic             capture,
  output logic             sub_step,
  output logic             decide,
  output logic             busy,
  output logic             adc_pwr_en
);

  // True when the phase counter sits in the final cycle of a phase of
  // programmed length len, a zero length counting as one cycle.
  function automatic logic at_last(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] len);
    logic [CNT_W:0] need;
    need = (len == '0) ? (CNT_W+1)'(1) : {1'b0, len};
    return ({1'b0, cnt} + (CNT_W+1)'(1)) >= need;
  endfunction

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] on_q, wait_q, xfer_q;
  logic             last_on, last_wait, last_xfer;

  assign last_on   = at_last(cnt_q, on_q);
  assign last_wait = at_last(cnt_q, wait_q);
  assign last_xfer = at_last(cnt_q, xfer_q);

  assign accept     = (phase_q == PH_IDLE) && probe_req;
  assign capture    = (phase_q == PH_WAIT) && last_wait && adc_valid;
  assign sub_step   = (phase_q == PH_SUB);
  assign decide     = (phase_q == PH_BRANCH);
  assign busy       = (phase_q != PH_IDLE);
  assign adc_pwr_en = (phase_q == PH_PWR_ON) || (phase_q == PH_WAIT) ||
                      (phase_q == PH_XFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      on_q    <= '0;
      wait_q  <= '0;
      xfer_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (probe_req) begin
            on_q    <= on_cycles;
            wait_q  <= wait_cycles;
            xfer_q  <= xfer_cycles;
            cnt_q   <= '0;
            phase_q <= PH_PWR_ON;
          end
        end
        PH_PWR_ON: begin
          if (last_on) begin
            cnt_q   <= '0;
            phase_q <= PH_WAIT;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_WAIT: begin
          if (last_wait) begin
            if (adc_valid) begin
              cnt_q   <= '0;
              phase_q <= PH_XFER;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_XFER: begin
          if (last_xfer) begin
            cnt_q   <= '0;
            phase_q <= PH_PWR_OFF;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_PWR_OFF: phase_q <= PH_SUB;
        PH_SUB:     phase_q <= PH_BRANCH;
        PH_BRANCH:  phase_q <= PH_IDLE;
        default:    phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/probe_compare.sv
module probe_compare #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] threshold,
  input  logic              capture,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              sub_step,
  input  logic              decide,
  output logic              done,
  output logic              ckpt_req,
  output logic              ret
);

  localparam int EXT_W = DATA_W + 1;

  // Sample minus threshold with one extra bit; the top bit is the borrow.
  function automatic logic [EXT_W-1:0] diff_ext(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  logic [DATA_W-1:0] sample_q, thr_q;
  logic [EXT_W-1:0]  diff_q;
  logic              borrow;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= '0;
      thr_q    <= '0;
      diff_q   <= '0;
    end else begin
      if (accept)   thr_q    <= threshold;
      if (capture)  sample_q <= adc_data;
      if (sub_step) diff_q   <= diff_ext(sample_q, thr_q);
    end
  end

  assign borrow   = diff_q[EXT_W-1];
  assign done     = decide;
  assign ckpt_req = decide && borrow;
  assign ret      = decide && !borrow;

endmodule

// File: rtl/probe_cycle_counter.sv
module probe_cycle_counter #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             busy,
  output logic [CYC_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (accept) count <= '0;
    else if (busy)   count <= count + CYC_W'(1);
  end

endmodule

// File: rtl/energy_probe_seq.sv
module energy_probe_seq #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 8,
  parameter int CYC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              probe_req,
  input  logic [CNT_W-1:0]  on_cycles,
  input  logic [CNT_W-1:0]  wait_cycles,
  input  logic [CNT_W-1:0]  xfer_cycles,
  input  logic [DATA_W-1:0] threshold,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_pwr_en,
  output logic              busy,
  output logic              done,
  output logic              ckpt_req,
  output logic              ret,
  output logic [CYC_W-1:0]  probe_cycles
);

  logic accept;
  logic capture;
  logic sub_step;
  logic decide;

  probe_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .probe_req  (probe_req),
    .on_cycles  (on_cycles),
    .wait_cycles(wait_cycles),
    .xfer_cycles(xfer_cycles),
    .adc_valid  (adc_valid),
    .accept     (accept),
    .capture    (capture),
    .sub_step   (sub_step),
    .decide     (decide),
    .busy       (busy),
    .adc_pwr_en (adc_pwr_en)
  );

  probe_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .threshold(threshold),
    .capture  (capture),
    .adc_data (adc_data),
    .sub_step (sub_step),
    .decide   (decide),
    .done     (done),
    .ckpt_req (ckpt_req),
    .ret      (ret)
  );

  probe_cycle_counter #(.CYC_W(CYC_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .busy  (busy),
    .count (probe_cycles)
  );

endmodule

// File: rtl/energy_probe_seq_chk.sv
module energy_probe_seq_chk #(
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             probe_req,
  input logic             accept,
  input logic             capture,
  input logic             busy,
  input logic             adc_pwr_en,
  input logic             done,
  input logic             ckpt_req,
  input logic             ret,
  input logic [CYC_W-1:0] probe_cycles
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy && !adc_pwr_en && !done && probe_cycles == '0));

  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && probe_cycles == '0));

  assert_done_ends_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  assert_power_in_probe_R3: assert property (@(posedge clk) disable iff (rst)
    adc_pwr_en |-> (busy && !done));

  assert_capture_powered_R5: assert property (@(posedge clk) disable iff (rst)
    capture |-> adc_pwr_en);

  assert_single_decision_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot0({ckpt_req, ret}) && (ckpt_req || ret));

  assert_decision_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    (ckpt_req || ret) |-> done);

  assert_busy_no_accept_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept);

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> probe_cycles == CYC_W'($past(probe_cycles) + 1'b1));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !probe_req) |=> $stable(probe_cycles));

endmodule

bind energy_probe_seq energy_probe_seq_chk #(.CYC_W(CYC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .probe_req   (probe_req),
  .accept      (accept),
  .capture     (capture),
  .busy        (busy),
  .adc_pwr_en  (adc_pwr_en),
  .done        (done),
  .ckpt_req    (ckpt_req),
  .ret         (ret),
  .probe_cycles(probe_cycles)
);

// File: tb/energy_probe_seq_tb_top.sv
module energy_probe_seq_tb_top;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;
  localparam int CYC_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              probe_req = 1'b0;
  logic [CNT_W-1:0]  on_cycles = '0;
  logic [CNT_W-1:0]  wait_cycles = '0;
  logic [CNT_W-1:0]  xfer_cycles = '0;
  logic [DATA_W-1:0] threshold = '0;
  logic              adc_valid = 1'b0;
  logic [DATA_W-1:0] adc_data = '0;
  logic              adc_pwr_en, busy, done, ckpt_req, ret;
  logic [CYC_W-1:0]  probe_cycles;

  int compared = 0;
  int mismatched = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  energy_probe_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) dut_i (
    .clk(clk), .rst(rst), .probe_req(probe_req),
    .on_cycles(on_cycles), .wait_cycles(wait_cycles), .xfer_cycles(xfer_cycles),
    .threshold(threshold), .adc_valid(adc_valid), .adc_data(adc_data),
    .adc_pwr_en(adc_pwr_en), .busy(busy), .done(done), .ckpt_req(ckpt_req),
    .ret(ret), .probe_cycles(probe_cycles)
  );

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  function automatic int clamp1(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // One probe; vdelay is the first cycle (1 = the cycle after acceptance) with adc_valid high.
  task automatic run_probe(input int on, input int wt, input int xf,
                           input int thr, input int d, input int vdelay);
    int p, lw, x, wtot, total, pwr_cnt, busy_cnt, done_c, cnt_at_done;
    bit pwr_bad, saw_ckpt, saw_ret;
    p = clamp1(on); lw = clamp1(wt); x = clamp1(xf);
    wtot = (vdelay - p > lw) ? vdelay - p : lw;
    total = p + wtot + x + 3;
    pwr_cnt = 0; busy_cnt = 0; done_c = -1; cnt_at_done = -1;
    pwr_bad = 0; saw_ckpt = 0; saw_ret = 0;
    @(negedge clk);
    on_cycles = CNT_W'(on); wait_cycles = CNT_W'(wt); xfer_cycles = CNT_W'(xf);
    threshold = DATA_W'(thr); adc_data = DATA_W'(d);
    adc_valid = (vdelay <= 0);
    probe_req = 1'b1;
    for (int c = 1; c < 400; c++) begin
      @(negedge clk);
      if (adc_pwr_en) begin
        pwr_cnt++;
        if (c > p + wtot + x) pwr_bad = 1;
      end
      if (busy) busy_cnt++;
      if (done) begin
        done_c = c; saw_ckpt = ckpt_req; saw_ret = ret;
        cnt_at_done = int'(probe_cycles);
      end
      // R9: scramble settings once the probe has been accepted
      if (c == 1) begin
        on_cycles = '1; wait_cycles = '0; xfer_cycles = '1; threshold = ~DATA_W'(thr);
      end
      adc_valid = (c >= vdelay);
      // R5: data becomes wrong right after the capture cycle
      adc_data = (c <= p + wtot) ? DATA_W'(d) : ~DATA_W'(d);
      // R7: requests while busy, including in the done cycle
      probe_req = (c == 2) || done;
      if (done) break;
    end
    check(done_c == total, "R4/R9/R10 done cycle", done_c, total);
    check(pwr_cnt == p + wtot + x && !pwr_bad, "R3 powered cycles", pwr_cnt, p + wtot + x);
    check(busy_cnt == total, "R2 busy cycles", busy_cnt, total);
    check(saw_ckpt == (d < thr), "R6 ckpt_req", int'(saw_ckpt), int'(d < thr));
    check(saw_ret == !(d < thr), "R5 ret", int'(saw_ret), int'(!(d < thr)));
    check(cnt_at_done == total - 1, "R8 count at done", cnt_at_done, total - 1);
    @(negedge clk);
    probe_req = 1'b0;
    check(!busy, "R7 no restart after done", int'(busy), 0);
    check(int'(probe_cycles) == total, "R8 final count", int'(probe_cycles), total);
    @(negedge clk);
    check(!busy && !adc_pwr_en && int'(probe_cycles) == total, "R8 count holds",
          int'(probe_cycles), total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    int thr_tab[7];
    int dat_tab[7];
    thr_tab = '{100, 100, 100, 0, 255, 255, 1};
    dat_tab = '{99, 100, 101, 0, 0, 255, 0};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!adc_pwr_en && !busy && !done && !ckpt_req && !ret && probe_cycles == '0,
          "R1 reset state", int'(probe_cycles), 0);
    repeat (3) @(negedge clk);
    check(!busy && !adc_pwr_en, "R2 idle without request", int'(busy), 0);

    // R1: reset in the middle of a powered phase
    on_cycles = 4'd3; wait_cycles = 4'd2; xfer_cycles = 4'd1; threshold = 8'd50;
    adc_valid = 1'b1; probe_req = 1'b1;
    @(negedge clk);
    probe_req = 1'b0;
    check(adc_pwr_en && busy, "R3 power after accept", int'(adc_pwr_en), 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!adc_pwr_en && !busy && !done && probe_cycles == '0, "R1 mid-probe reset",
          int'(adc_pwr_en), 0);

    for (int on = 0; on < 4; on++)
      for (int wi = 0; wi < 3; wi++)
        for (int xf = 0; xf < 3; xf++)
          for (int k = 0; k < 7; k++) begin
            int wt;
            int vd;
            wt = (wi == 2) ? 3 : wi;
            vd = (k % 2 == 1) ? clamp1(on) + clamp1(wt) + 3 : 0;
            run_probe(on, wt, xf, thr_tab[k], dat_tab[k], vd);
          end
    report();
  end

endmodule